// File: doc/BRIEF.md
# Link-Layer Wake Request Generator

This block sits inside a serial-bus physical layer and decides when the sleeping link-layer controller must be woken. It watches the link's power-status input and its link-control bit. It takes several wake causes: a one-cycle pulse for a received link-on packet addressed to this node, the level-sensitive interrupt bits with their resume enable, and a one-cycle power-cycle event that carries the node's power class. While a cause is present and the link is inactive, the block drives an 8-cycle square wave on the wake pin.

The causes are cleared in different ways. A packet cause is sticky and clears when the link comes up. A bus reset also clears it, but only if no other cause is present. Interrupt causes follow their input levels, so a wake fires again whenever the link drops while an interrupt is still pending. A power-cycle cause ends when the link comes up or when a long timeout counter expires. During hardware reset the pad output is disabled, and the pin level is captured as the port-mode strap.

Top module: `link_wake_gen`

## Requirements
- R1: While a wake is requested, `wake_out` repeats a pattern of 4 cycles high then 4 cycles low, starting high. For a packet cause, the first high sample comes 2 clock edges after the pulse.
- R2: `wake_oe` is 0 while `rst_n` is low and 1 after reset is released. `wake_out` is 0 whenever no wake is requested.
- R3: The link is active when `link_pwr_on`=1 and `link_ctl`=1. While the link is active, `wake_out` stays 0 and a packet pulse is discarded.
- R4: Each of these causes a wake while the link is inactive: a `pkt_wake` pulse (held as a sticky cause), `irq_port_event`=1, or any of `irq_cfg_tmo`, `irq_cable_pwr`, `irq_state_tmo` set together with `irq_resume_en`=1. Those three interrupts have no effect while `irq_resume_en`=0.
- R5: Once a packet cause has been latched, the wake continues until the link becomes active. After that the packet cause is gone.
- R6: A `bus_reset` pulse cancels a wake whose only cause is a latched packet.
- R7: A `bus_reset` pulse cancels neither an interrupt-held wake nor a packet cause latched alongside an interrupt cause. The packet cause persists after the interrupt clears.
- R8: An interrupt cause present while the link is active produces a wake as soon as the link becomes inactive.
- R9: A `pwr_cycle` pulse with `pwr_class` 0 to 4 while the link is inactive starts a wake. Classes 5 to 7 start none, and `bus_reset` does not cancel a power-cycle wake.
- R10: A power-cycle wake stops after `PWR_TMO_CYCLES` clock cycles if the link has not become active.
- R11: `port_legacy` holds the `pad_in` level seen during reset (0 = dual-mode port, 1 = legacy-only port) and does not change after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| pad_in | input | 1 | Level read back from the wake pin, used for the strap |
| link_pwr_on | input | 1 | Link power-status input, 1 = powered |
| link_ctl | input | 1 | Link-control bit |
| pkt_wake | input | 1 | One-cycle pulse: link-on packet for this node received |
| irq_port_event | input | 1 | Port-event interrupt bit |
| irq_cfg_tmo | input | 1 | Configuration-timeout interrupt bit |
| irq_cable_pwr | input | 1 | Cable-power-status interrupt bit |
| irq_state_tmo | input | 1 | State-timeout interrupt bit |
| irq_resume_en | input | 1 | Resuming-port interrupt enable |
| bus_reset | input | 1 | One-cycle bus-reset event |
| pwr_cycle | input | 1 | One-cycle power-cycle event |
| pwr_class | input | 3 | Node power class |
| wake_out | output | 1 | Wake waveform to the pad |
| wake_oe | output | 1 | Pad output enable |
| port_legacy | output | 1 | Captured port-mode strap |

## Verification
A chain of vectors carries state from one step to the next. Each step tries the wake decision with one pattern: a lone packet pulse, a packet followed by bus reset, each interrupt with and without its enable, a link that drops while an interrupt is pending, and a packet combined with an interrupt under bus reset. Counting the high cycles in a 16-cycle window separates a running wave (8 highs) from an idle pin (0). These patterns show which cause held the wake and which clearing rule applied. Directed tests then check the exact 4-high/4-low shape, the power-class boundary at 4 and 5, the power-cycle timeout (with a bus reset in the middle), and the strap value captured for each pin level.

// File: rtl/lw_pkg.sv
package lw_pkg;
  // largest power class that still raises a wake after a power cycle
  localparam int unsigned MAX_WAKE_CLASS = 4;
  // cycles the wave stays high, and then low, in each period
  localparam int unsigned WAVE_HALF = 4;

  typedef struct packed {
    logic port_event;
    logic cfg_tmo;
    logic cable_pwr;
    logic state_tmo;
  } irq_bits_t;
endpackage

// File: rtl/lw_rst_sync.sv
module lw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lw_cause.sv
module lw_cause
  import lw_pkg::*;
#(
  parameter longint unsigned PWR_TMO_CYCLES = 64'd8208384000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      link_active,
  input  logic      pkt_rx,
  input  logic      bus_reset,
  input  logic      pwr_cycle,
  input  logic [2:0] pwr_class,
  input  irq_bits_t irq,
  input  logic      irq_en,
  output logic      wake_req
);
  localparam int unsigned CNT_W = (PWR_TMO_CYCLES > 1) ? $clog2(PWR_TMO_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWR_TMO_CYCLES - 1);

  logic             pkt_q, pkt_d;
  logic             pwr_q, pwr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_cause;
  logic             pwr_start;
  logic             pkt_cancel;

  always_comb begin
    irq_cause  = irq.port_event | (irq_en & (irq.cfg_tmo | irq.cable_pwr | irq.state_tmo));
    pwr_start  = pwr_cycle & (pwr_class <= 3'(MAX_WAKE_CLASS)) & ~link_active;
    pkt_cancel = bus_reset & ~irq_cause & ~pwr_q;

    // sticky packet cause
    if (link_active)     pkt_d = 1'b0;
    else if (pkt_rx)     pkt_d = 1'b1;
    else if (pkt_cancel) pkt_d = 1'b0;
    else                 pkt_d = pkt_q;

    // power-cycle cause with timeout
    pwr_d = pwr_q;
    cnt_d = cnt_q;
    if (link_active) begin
      pwr_d = 1'b0;
      cnt_d = '0;
    end else if (pwr_start) begin
      pwr_d = 1'b1;
      cnt_d = '0;
    end else if (pwr_q) begin
      if (cnt_q == CNT_LAST) begin
        pwr_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    wake_req = ~link_active & (irq_cause | pkt_q | pwr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_q <= 1'b0;
      pwr_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pkt_q <= pkt_d;
      pwr_q <= pwr_d;
      cnt_q <= cnt_d;
    end
  end

  AST_PKT_ONLY_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !pkt_rx && !irq_cause && !pwr_q) |=> !pkt_q); // R6
  AST_PKT_KEPT_BY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && irq_cause && pkt_q && !link_active) |=> pkt_q); // R7
  AST_HIGH_CLASS_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_cycle && pwr_class > 3'(MAX_WAKE_CLASS) && !pwr_q) |=> !pwr_q); // R9
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R10
endmodule

// File: rtl/lw_wave.sv
module lw_wave
  import lw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wake_req,
  output logic wave
);
  localparam int unsigned PERIOD = 2 * WAVE_HALF;
  localparam int unsigned PH_W   = $clog2(PERIOD);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

  logic            run_q, run_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            out_q, out_d;

  always_comb begin
    if (wake_req) begin
      run_d = 1'b1;
      if (!run_q || ph_q == PH_LAST) ph_d = '0;
      else                           ph_d = ph_q + 1'b1;
      out_d = (ph_d < PH_W'(WAVE_HALF));
    end else begin
      run_d = 1'b0;
      ph_d  = '0;
      out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= '0;
      out_q <= 1'b0;
    end else begin
      run_q <= run_d;
      ph_q  <= ph_d;
      out_q <= out_d;
    end
  end

  assign wave = out_q;

  // length of the current run of high output cycles, kept for the checks
  logic [3:0] high_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     high_run_q <= '0;
    else if (out_q) high_run_q <= (high_run_q == 4'hF) ? high_run_q : high_run_q + 1'b1;
    else            high_run_q <= '0;
  end

  AST_HIGH_RUN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    high_run_q <= 4'(WAVE_HALF)); // R1
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_req |=> !out_q); // R2
endmodule

// File: rtl/link_wake_gen.sv
module link_wake_gen
  import lw_pkg::*;
#(
  parameter longint unsigned PWR_TMO_CYCLES = 64'd8208384000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pad_in,
  input  logic       link_pwr_on,
  input  logic       link_ctl,
  input  logic       pkt_wake,
  input  logic       irq_port_event,
  input  logic       irq_cfg_tmo,
  input  logic       irq_cable_pwr,
  input  logic       irq_state_tmo,
  input  logic       irq_resume_en,
  input  logic       bus_reset,
  input  logic       pwr_cycle,
  input  logic [2:0] pwr_class,
  output logic       wake_out,
  output logic       wake_oe,
  output logic       port_legacy
);
  logic      rst_sync_n;
  logic      link_active;
  logic      wake_req;
  logic      strap_q;
  irq_bits_t irq;

  lw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign link_active = link_pwr_on & link_ctl;
  assign irq = '{port_event: irq_port_event, cfg_tmo: irq_cfg_tmo,
                 cable_pwr: irq_cable_pwr, state_tmo: irq_state_tmo};

  lw_cause #(.PWR_TMO_CYCLES(PWR_TMO_CYCLES)) u_cause (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .link_active (link_active),
    .pkt_rx      (pkt_wake),
    .bus_reset   (bus_reset),
    .pwr_cycle   (pwr_cycle),
    .pwr_class   (pwr_class),
    .irq         (irq),
    .irq_en      (irq_resume_en),
    .wake_req    (wake_req)
  );

  lw_wave u_wave (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wake_req (wake_req),
    .wave     (wake_out)
  );

  // strap: the pin level is loaded on every cycle of reset and held afterwards
  always_ff @(posedge clk) begin
    if (!rst_sync_n) strap_q <= pad_in;
  end

  assign port_legacy = strap_q;
  assign wake_oe     = rst_sync_n;

  AST_QUIET_WHEN_LINK_UP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_active |=> !wake_out); // R3
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> $stable(port_legacy)); // R11
endmodule

// File: tb/link_wake_gen_bench.sv
module link_wake_gen_bench;
  localparam int unsigned TMO = 40;

  logic clk = 1'b0;
  logic rst_n, pad_in, link_pwr_on, link_ctl, pkt_wake;
  logic irq_port_event, irq_cfg_tmo, irq_cable_pwr, irq_state_tmo, irq_resume_en;
  logic bus_reset, pwr_cycle;
  logic [2:0] pwr_class;
  logic wake_out, wake_oe, port_legacy;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  link_wake_gen #(.PWR_TMO_CYCLES(64'(TMO))) u_link_wake_gen (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .link_pwr_on(link_pwr_on),
    .link_ctl(link_ctl), .pkt_wake(pkt_wake), .irq_port_event(irq_port_event),
    .irq_cfg_tmo(irq_cfg_tmo), .irq_cable_pwr(irq_cable_pwr),
    .irq_state_tmo(irq_state_tmo), .irq_resume_en(irq_resume_en),
    .bus_reset(bus_reset), .pwr_cycle(pwr_cycle), .pwr_class(pwr_class),
    .wake_out(wake_out), .wake_oe(wake_oe), .port_legacy(port_legacy)
  );

  // [9]pwr_on [8]ctl [7]pkt pulse [6]bus_reset pulse [5]port_event
  // [4]cfg_tmo [3]cable_pwr [2]state_tmo [1]resume_en [0]expect wave
  localparam int NV = 24;
  localparam logic [9:0] VEC [NV] = '{
    10'b11_00_0000_0_0,  // R3 link up, idle
    10'b10_00_0000_0_0,  // R2 link down, no cause
    10'b10_10_0000_0_1,  // R4 packet wake
    10'b10_01_0000_0_0,  // R6 bus reset cancels packet-only wake
    10'b10_10_0000_0_1,  // R4 packet wake again
    10'b11_00_0000_0_0,  // R5 link up stops it
    10'b10_00_0000_0_0,  // R5 packet cause gone
    10'b10_00_1000_0_1,  // R4 port event
    10'b10_01_1000_0_1,  // R7 survives bus reset
    10'b10_00_0000_0_0,  // R4 level cause removed
    10'b10_00_0100_0_0,  // R4 cfg timeout without enable
    10'b10_00_0100_1_1,  // R4 cfg timeout with enable
    10'b11_00_0100_1_0,  // R3 link up blocks wake
    10'b01_00_0100_1_1,  // R8 link drops with irq pending
    10'b01_00_0000_1_0,  // R4 cleared
    10'b01_10_0001_1_1,  // R4 packet plus state timeout
    10'b01_01_0001_1_1,  // R7 bus reset with irq present
    10'b01_00_0000_1_1,  // R7 packet cause remains
    10'b11_00_0000_1_0,  // R5 link up clears
    10'b11_10_0000_0_0,  // R3 packet while link up
    10'b10_00_0000_0_0,  // R3 packet discarded
    10'b10_00_0010_0_0,  // R4 cable power without enable
    10'b10_00_0010_1_1,  // R4 cable power with enable
    10'b10_00_0000_0_0   // R2 idle
  };
  localparam int VREQ [NV] = '{3,2,4,6,4,5,5,4,7,4,4,4,3,8,4,4,7,7,5,3,3,4,4,2};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_high(input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (wake_out) n++;
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    pad_in = strap;
    repeat (4) @(negedge clk);
    check(wake_oe == 1'b0, "R2", wake_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pad_in = ~strap;
    repeat (2) @(negedge clk);
    check(wake_oe == 1'b1, "R2", wake_oe, 1);
    check(wake_out == 1'b0, "R2", wake_out, 0);
    check(port_legacy == strap, "R11", port_legacy, strap);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    logic [9:0] v;
    rst_n = 1'b0; pad_in = 1'b0; link_pwr_on = 1'b1; link_ctl = 1'b1;
    pkt_wake = 0; irq_port_event = 0; irq_cfg_tmo = 0; irq_cable_pwr = 0;
    irq_state_tmo = 0; irq_resume_en = 0; bus_reset = 0; pwr_cycle = 0;
    pwr_class = 3'd0;

    do_reset(1'b1);  // R11 legacy strap

    // vector table
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      @(negedge clk);
      link_pwr_on = v[9]; link_ctl = v[8]; pkt_wake = v[7]; bus_reset = v[6];
      irq_port_event = v[5]; irq_cfg_tmo = v[4]; irq_cable_pwr = v[3];
      irq_state_tmo = v[2]; irq_resume_en = v[1];
      @(negedge clk);
      pkt_wake = 1'b0; bus_reset = 1'b0;
      repeat (2) @(negedge clk);
      count_high(16, n);
      check(n == (v[0] ? 8 : 0), $sformatf("R%0d vec%0d", VREQ[k], k), n, v[0] ? 8 : 0);
    end

    // R1 exact wave shape after a packet pulse
    begin
      logic [9:0] seen;
      logic [9:0] want;
      want = 10'b0_1111_0000_1;
      link_pwr_on = 1'b1; link_ctl = 1'b0;
      repeat (3) @(negedge clk);
      pkt_wake = 1'b1;
      for (int i = 9; i >= 0; i--) begin
        @(negedge clk);
        pkt_wake = 1'b0;
        seen[i] = wake_out;
      end
      check(seen == want, "R1", seen, want);
      link_ctl = 1'b1;
      repeat (3) @(negedge clk);
    end

    // R9 class 5 gives no wake
    link_ctl = 1'b0;
    @(negedge clk);
    pwr_class = 3'd5; pwr_cycle = 1'b1;
    @(negedge clk);
    pwr_cycle = 1'b0;
    repeat (2) @(negedge clk);
    count_high(16, n);
    check(n == 0, "R9 class5", n, 0);

    // R9 class 4 wakes, R9 survives bus reset, R10 timeout
    @(negedge clk);
    pwr_class = 3'd4; pwr_cycle = 1'b1;
    @(negedge clk);
    pwr_cycle = 1'b0;
    repeat (2) @(negedge clk);
    count_high(16, n);
    check(n == 8, "R9 class4", n, 8);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    count_high(8, n);
    check(n == 4, "R9 bus reset", n, 4);
    repeat (TMO) @(negedge clk);
    count_high(16, n);
    check(n == 0, "R10 timeout", n, 0);
    link_ctl = 1'b1;

    do_reset(1'b0);  // R11 dual-mode strap
    finish_run();
  end
endmodule